// File: doc/BRIEF.md
# Polled RTC Interrupt Flag Generator

This block produces real-time-clock style interrupt flags on a chip that has no dedicated RTC interrupt source. A timer channel elsewhere delivers a poll strobe. On each strobe the block samples the current time of day and decides whether to raise three kinds of event: an update event when the seconds value has moved, an alarm event when the time equals a stored alarm time, and a periodic event derived from the strobe through a divider. When any event is raised, the block issues a one-cycle interrupt pulse and a composed flag word that a downstream RTC handler decodes.

Software-style control arrives as simple register writes: set and clear masks for the three enables, an alarm time write, and a periodic rate write given as the base-2 logarithm of the rate in hertz. The block tells the timer channel whether polling is needed at all and what poll rate to run at. The default poll rate is 2^6 = 64 Hz. Periodic rates above that raise the poll rate itself. The timer channel may also report how many strobes it missed, and those are credited to the periodic divider.

Top module: `rtc_emu_flaggen`

## Requirements
- R1: After reset all enables are off, the alarm time is 0:00:00, the rate code is 6, the recorded seconds value is 0, the divider count is 0, and the outputs are irq_pulse=0, flag_word=0, poll_en=0, poll_shift=6.
- R2: With the update enable (enable bit 0) set, a strobe whose cur_sec differs from the recorded seconds sets flag_word bit 4 and records cur_sec. The recorded value changes only on strobes taken while the update enable is set.
- R3: With the alarm enable (enable bit 1) set, every strobe whose cur_hour, cur_min and cur_sec all equal the stored alarm fields sets flag_word bit 6's neighbour, bit 5.
- R4: With the periodic enable (enable bit 2) set, each strobe forms sum = count + missed_ticks + 1. The limit is 64 >> rate code for codes up to 6 and 1 above 6. If sum >= limit, flag_word bit 6 is set and the count returns to 0, otherwise the count becomes sum. The count is held at 0 while the periodic enable is off and is cleared by a rate write.
- R5: missed_ticks sampled with a strobe is credited to the divider. Any excess of the sum beyond the limit is discarded when the periodic event fires.
- R6: A rate write stores rate_code clamped to the range 1 to 13 (2 Hz to 8192 Hz).
- R7: One cycle after a strobe that raises at least one event, irq_pulse is high for exactly one cycle and flag_word has bit 7 set, bits 15:8 equal to 1, bits 3:0 zero, and the event bits of that strobe. In every other cycle flag_word is 0 and irq_pulse is 0.
- R8: poll_en is high when any enable is set. A strobe taken while no enable is set has no effect.
- R9: poll_shift equals the stored rate code when the periodic enable is set and the code exceeds 6. Otherwise it equals 6.
- R10: An enable write applies the clear mask first and then the set mask, so a bit in both masks ends up set. Enable, alarm and rate writes made in the same cycle as a strobe affect only later strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_strobe | input | 1 | One-cycle poll strobe from the timer channel |
| cur_hour | input | HOUR_W | Current hours |
| cur_min | input | MIN_W | Current minutes |
| cur_sec | input | SEC_W | Current seconds |
| missed_ticks | input | MISS_W | Strobes missed before this one |
| en_set | input | 3 | Enable set mask (bit0 update, bit1 alarm, bit2 periodic) |
| en_clr | input | 3 | Enable clear mask, same bit order |
| alarm_wr | input | 1 | Alarm time write strobe |
| alarm_hour | input | HOUR_W | Alarm hours to store |
| alarm_min | input | MIN_W | Alarm minutes to store |
| alarm_sec | input | SEC_W | Alarm seconds to store |
| rate_wr | input | 1 | Periodic rate write strobe |
| rate_code | input | RATE_W | Periodic rate as log2 of hertz |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| flag_word | output | 16 | Composed flag word |
| poll_en | output | 1 | Polling required |
| poll_shift | output | RATE_W | Requested poll rate as log2 of hertz |

## Verification
Two pairs of events can share a strobe. An update and an alarm coincide when the seconds step onto the stored alarm time, and the periodic event can join them while all three enables are set. The bench steps the time onto the alarm with every enable on and expects one pulse whose word carries several event bits. A further case puts a write in the same cycle as a strobe, and the bench expects that strobe to be judged with the old settings. The behavioural model compares the flag word, the pulse and both poll outputs on every clock.

// File: rtl/rtc_emu_pkg.sv
package rtc_emu_pkg;

    localparam int FLAG_W      = 16;
    localparam int BIT_UPD     = 4;
    localparam int BIT_ALM     = 5;
    localparam int BIT_PER     = 6;
    localparam int BIT_PEND    = 7;
    localparam int CNT_LSB     = 8;

    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } en_t;

    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } hit_t;

    function automatic logic any_hit(hit_t h);
        return h.upd | h.alm | h.per;
    endfunction

    // R7: pending bit, one-interrupt count and event bits
    function automatic logic [FLAG_W-1:0] compose_word(hit_t h);
        logic [FLAG_W-1:0] w;
        w = '0;
        if (any_hit(h)) begin
            w[BIT_UPD]            = h.upd;
            w[BIT_ALM]            = h.alm;
            w[BIT_PER]            = h.per;
            w[BIT_PEND]           = 1'b1;
            w[FLAG_W-1:CNT_LSB]   = 8'd1;
        end
        return w;
    endfunction

    // R4: divide limit from rate code
    function automatic int unsigned div_limit(int unsigned code, int unsigned def_shift);
        if (code <= def_shift)
            return 32'd1 << (def_shift - code);
        return 32'd1;
    endfunction

endpackage

// File: rtl/rtc_emu_regs.sv
module rtc_emu_regs
    import rtc_emu_pkg::*;
#(
    parameter int HOUR_W    = 5,
    parameter int MIN_W     = 6,
    parameter int SEC_W     = 6,
    parameter int RATE_W    = 4,
    parameter int DEF_SHIFT = 6,
    parameter int MIN_CODE  = 1,
    parameter int MAX_CODE  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        en_set,
    input  logic [2:0]        en_clr,
    input  logic              alarm_wr,
    input  logic [HOUR_W-1:0] alarm_hour,
    input  logic [MIN_W-1:0]  alarm_min,
    input  logic [SEC_W-1:0]  alarm_sec,
    input  logic              rate_wr,
    input  logic [RATE_W-1:0] rate_code,
    output en_t               en_q,
    output logic [HOUR_W-1:0] alm_h_q,
    output logic [MIN_W-1:0]  alm_m_q,
    output logic [SEC_W-1:0]  alm_s_q,
    output logic [RATE_W-1:0] rate_q,
    output logic [RATE_W-1:0] shift_o
);

    localparam logic [RATE_W-1:0] CODE_LO  = RATE_W'(MIN_CODE);
    localparam logic [RATE_W-1:0] CODE_HI  = RATE_W'(MAX_CODE);
    localparam logic [RATE_W-1:0] CODE_DEF = RATE_W'(DEF_SHIFT);

    logic [RATE_W-1:0] code_clamped;

    // R6: clamp requested rate
    always_comb begin
        if (rate_code < CODE_LO)
            code_clamped = CODE_LO;
        else if (rate_code > CODE_HI)
            code_clamped = CODE_HI;
        else
            code_clamped = rate_code;
    end

    // R10: clear mask then set mask
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            en_q <= en_t'((3'(en_q) & ~en_clr) | en_set);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alm_h_q <= '0;
            alm_m_q <= '0;
            alm_s_q <= '0;
        end else if (alarm_wr) begin
            alm_h_q <= alarm_hour;
            alm_m_q <= alarm_min;
            alm_s_q <= alarm_sec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rate_q <= CODE_DEF;
        else if (rate_wr)
            rate_q <= code_clamped;
    end

    // R9: poll rate request
    always_comb begin
        if (en_q.per && (rate_q > CODE_DEF))
            shift_o = rate_q;
        else
            shift_o = CODE_DEF;
    end

endmodule

// File: rtl/rtc_emu_match.sv
module rtc_emu_match
    import rtc_emu_pkg::*;
#(
    parameter int HOUR_W = 5,
    parameter int MIN_W  = 6,
    parameter int SEC_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act,
    input  en_t               en,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [SEC_W-1:0]  cur_sec,
    input  logic [HOUR_W-1:0] alm_h,
    input  logic [MIN_W-1:0]  alm_m,
    input  logic [SEC_W-1:0]  alm_s,
    output logic              hit_upd,
    output logic              hit_alm
);

    logic [SEC_W-1:0] last_sec_q;
    logic             time_eq;

    assign time_eq = (cur_hour == alm_h) && (cur_min == alm_m) && (cur_sec == alm_s);

    // R2: seconds moved since last recorded
    assign hit_upd = act && en.upd && (cur_sec != last_sec_q);
    // R3: full time match
    assign hit_alm = act && en.alm && time_eq;

    always_ff @(posedge clk) begin
        if (rst)
            last_sec_q <= '0;
        else if (act && en.upd)
            last_sec_q <= cur_sec;
    end

endmodule

// File: rtl/rtc_emu_pdiv.sv
module rtc_emu_pdiv
    import rtc_emu_pkg::*;
#(
    parameter int RATE_W    = 4,
    parameter int MISS_W    = 4,
    parameter int CNT_W     = 8,
    parameter int DEF_SHIFT = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act,
    input  logic              pie,
    input  logic              clr,
    input  logic [RATE_W-1:0] rate,
    input  logic [MISS_W-1:0] missed,
    output logic              hit_per
);

    localparam int SUM_W = ((CNT_W > MISS_W) ? CNT_W : MISS_W) + 2;

    logic [CNT_W-1:0] cnt_q;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] limit;

    // R4, R5: credit missed strobes plus this one
    assign sum   = SUM_W'(cnt_q) + SUM_W'(missed) + SUM_W'(1);
    assign limit = SUM_W'(div_limit(32'(rate), DEF_SHIFT));

    assign hit_per = act && pie && (sum >= limit);

    always_ff @(posedge clk) begin
        if (rst || clr || !pie)
            cnt_q <= '0;
        else if (act)
            cnt_q <= hit_per ? '0 : sum[CNT_W-1:0];
    end

endmodule

// File: rtl/rtc_emu_flaggen.sv
module rtc_emu_flaggen
    import rtc_emu_pkg::*;
#(
    parameter int HOUR_W    = 5,
    parameter int MIN_W     = 6,
    parameter int SEC_W     = 6,
    parameter int MISS_W    = 4,
    parameter int RATE_W    = 4,
    parameter int CNT_W     = 8,
    parameter int DEF_SHIFT = 6,
    parameter int MIN_CODE  = 1,
    parameter int MAX_CODE  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              poll_strobe,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [SEC_W-1:0]  cur_sec,
    input  logic [MISS_W-1:0] missed_ticks,
    input  logic [2:0]        en_set,
    input  logic [2:0]        en_clr,
    input  logic              alarm_wr,
    input  logic [HOUR_W-1:0] alarm_hour,
    input  logic [MIN_W-1:0]  alarm_min,
    input  logic [SEC_W-1:0]  alarm_sec,
    input  logic              rate_wr,
    input  logic [RATE_W-1:0] rate_code,
    output logic              irq_pulse,
    output logic [15:0]       flag_word,
    output logic              poll_en,
    output logic [RATE_W-1:0] poll_shift
);

    en_t               en_q;
    logic [HOUR_W-1:0] alm_h;
    logic [MIN_W-1:0]  alm_m;
    logic [SEC_W-1:0]  alm_s;
    logic [RATE_W-1:0] rate_q;
    logic              act;
    hit_t              hits;

    rtc_emu_regs #(
        .HOUR_W(HOUR_W), .MIN_W(MIN_W), .SEC_W(SEC_W), .RATE_W(RATE_W),
        .DEF_SHIFT(DEF_SHIFT), .MIN_CODE(MIN_CODE), .MAX_CODE(MAX_CODE)
    ) u_regs (
        .clk(clk), .rst(rst),
        .en_set(en_set), .en_clr(en_clr),
        .alarm_wr(alarm_wr), .alarm_hour(alarm_hour),
        .alarm_min(alarm_min), .alarm_sec(alarm_sec),
        .rate_wr(rate_wr), .rate_code(rate_code),
        .en_q(en_q), .alm_h_q(alm_h), .alm_m_q(alm_m), .alm_s_q(alm_s),
        .rate_q(rate_q), .shift_o(poll_shift)
    );

    // R8: polling only while any enable is set
    assign poll_en = en_q.upd | en_q.alm | en_q.per;
    assign act     = poll_strobe & poll_en;

    rtc_emu_match #(
        .HOUR_W(HOUR_W), .MIN_W(MIN_W), .SEC_W(SEC_W)
    ) u_match (
        .clk(clk), .rst(rst), .act(act), .en(en_q),
        .cur_hour(cur_hour), .cur_min(cur_min), .cur_sec(cur_sec),
        .alm_h(alm_h), .alm_m(alm_m), .alm_s(alm_s),
        .hit_upd(hits.upd), .hit_alm(hits.alm)
    );

    rtc_emu_pdiv #(
        .RATE_W(RATE_W), .MISS_W(MISS_W), .CNT_W(CNT_W), .DEF_SHIFT(DEF_SHIFT)
    ) u_pdiv (
        .clk(clk), .rst(rst), .act(act), .pie(en_q.per), .clr(rate_wr),
        .rate(rate_q), .missed(missed_ticks), .hit_per(hits.per)
    );

    // R7: registered pulse and word
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pulse <= 1'b0;
            flag_word <= '0;
        end else begin
            irq_pulse <= any_hit(hits);
            flag_word <= compose_word(hits);
        end
    end

endmodule

// File: rtl/rtc_emu_flaggen_chk.sv
module rtc_emu_flaggen_chk #(
    parameter int RATE_W    = 4,
    parameter int DEF_SHIFT = 6,
    parameter int MAX_CODE  = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              poll_strobe,
    input logic              poll_en,
    input logic              irq_pulse,
    input logic [15:0]       flag_word,
    input logic [RATE_W-1:0] poll_shift
);

    p_irq_after_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> ($past(poll_strobe) && $past(poll_en)));

    p_irq_word_r7: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> (flag_word[7] && flag_word[15:8] == 8'd1 &&
                       flag_word[3:0] == 4'd0 && (|flag_word[6:4])));

    p_quiet_word_r7: assert property (@(posedge clk) disable iff (rst)
        !irq_pulse |-> (flag_word == 16'd0));

    p_idle_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        (poll_strobe && !poll_en) |=> !irq_pulse);

    p_shift_range_r9: assert property (@(posedge clk) disable iff (rst)
        (poll_shift >= RATE_W'(DEF_SHIFT)) && (poll_shift <= RATE_W'(MAX_CODE)));

    p_shift_needs_poll_r9: assert property (@(posedge clk) disable iff (rst)
        (poll_shift != RATE_W'(DEF_SHIFT)) |-> poll_en);

endmodule

bind rtc_emu_flaggen rtc_emu_flaggen_chk #(
    .RATE_W(RATE_W), .DEF_SHIFT(DEF_SHIFT), .MAX_CODE(MAX_CODE)
) u_chk (
    .clk(clk), .rst(rst), .poll_strobe(poll_strobe), .poll_en(poll_en),
    .irq_pulse(irq_pulse), .flag_word(flag_word), .poll_shift(poll_shift)
);

// File: tb/test_rtc_emu_flaggen.sv
`timescale 1ns/1ps
module test_rtc_emu_flaggen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        poll_strobe = 1'b0;
    logic [4:0]  cur_hour = '0;
    logic [5:0]  cur_min = '0;
    logic [5:0]  cur_sec = '0;
    logic [3:0]  missed_ticks = '0;
    logic [2:0]  en_set = '0;
    logic [2:0]  en_clr = '0;
    logic        alarm_wr = 1'b0;
    logic [4:0]  alarm_hour = '0;
    logic [5:0]  alarm_min = '0;
    logic [5:0]  alarm_sec = '0;
    logic        rate_wr = 1'b0;
    logic [3:0]  rate_code = '0;
    logic        irq_pulse;
    logic [15:0] flag_word;
    logic        poll_en;
    logic [3:0]  poll_shift;

    int n_tests = 0;
    int n_fail  = 0;
    int n_irq   = 0;
    int cyc     = 0;

    always #2 clk = ~clk;

    rtc_emu_flaggen i_rtc_emu_flaggen (
        .clk(clk), .rst(rst), .poll_strobe(poll_strobe),
        .cur_hour(cur_hour), .cur_min(cur_min), .cur_sec(cur_sec),
        .missed_ticks(missed_ticks), .en_set(en_set), .en_clr(en_clr),
        .alarm_wr(alarm_wr), .alarm_hour(alarm_hour), .alarm_min(alarm_min),
        .alarm_sec(alarm_sec), .rate_wr(rate_wr), .rate_code(rate_code),
        .irq_pulse(irq_pulse), .flag_word(flag_word), .poll_en(poll_en),
        .poll_shift(poll_shift)
    );

    // behavioural reference state
    int m_en, m_ah, m_am, m_as, m_rate, m_last, m_cnt, m_irq, m_word;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_en = 0; m_ah = 0; m_am = 0; m_as = 0; m_rate = 6;
            m_last = 0; m_cnt = 0; m_irq = 0; m_word = 0;
        end else begin
            int uf, af, pf, lim, s, old_en;
            uf = 0; af = 0; pf = 0; old_en = m_en;
            if (poll_strobe && m_en != 0) begin
                if ((m_en & 1) && int'(cur_sec) != m_last) begin
                    uf = 1; m_last = int'(cur_sec);
                end
                if ((m_en & 2) && int'(cur_hour) == m_ah && int'(cur_min) == m_am
                    && int'(cur_sec) == m_as) af = 1;
                if (m_en & 4) begin
                    lim = (m_rate <= 6) ? (64 >> m_rate) : 1;
                    s = m_cnt + int'(missed_ticks) + 1;
                    if (s >= lim) begin pf = 1; m_cnt = 0; end
                    else m_cnt = s;
                end
            end
            if (rate_wr || !(old_en & 4)) m_cnt = 0;
            m_irq  = uf | af | pf;
            m_word = m_irq ? (256 | 128 | (pf << 6) | (af << 5) | (uf << 4)) : 0;
            m_en = (m_en & ~int'(en_clr)) | int'(en_set);
            if (alarm_wr) begin
                m_ah = int'(alarm_hour); m_am = int'(alarm_min); m_as = int'(alarm_sec);
            end
            if (rate_wr) m_rate = (rate_code < 1) ? 1 : (rate_code > 13) ? 13 : int'(rate_code);
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk(int'(flag_word[4]), (m_word >> 4) & 1, "R2 update bit");
            chk(int'(flag_word[5]), (m_word >> 5) & 1, "R3 alarm bit");
            chk(int'(flag_word[6]), (m_word >> 6) & 1, "R4/R5 periodic bit");
            chk(int'(irq_pulse), m_irq, "R7 pulse");
            chk(int'(flag_word), m_word, "R7 word");
            chk(int'(poll_en), (m_en != 0) ? 1 : 0, "R8 poll enable");
            chk(int'(poll_shift), ((m_en & 4) && m_rate > 6) ? m_rate : 6, "R9/R6 poll shift");
            if (irq_pulse) n_irq++;
        end
    end

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input int h, input int m, input int s, input int miss);
        @(negedge clk);
        poll_strobe = 1; cur_hour = 5'(h); cur_min = 6'(m); cur_sec = 6'(s);
        missed_ticks = 4'(miss);
        @(negedge clk);
        poll_strobe = 0; missed_ticks = 0;
    endtask

    task automatic wr_en(input int set, input int clr);
        @(negedge clk); en_set = 3'(set); en_clr = 3'(clr);
        @(negedge clk); en_set = 0; en_clr = 0;
    endtask

    task automatic wr_alarm(input int h, input int m, input int s);
        @(negedge clk); alarm_wr = 1; alarm_hour = 5'(h); alarm_min = 6'(m); alarm_sec = 6'(s);
        @(negedge clk); alarm_wr = 0;
    endtask

    task automatic wr_rate(input int c);
        @(negedge clk); rate_wr = 1; rate_code = 4'(c);
        @(negedge clk); rate_wr = 0;
    endtask

    initial begin
        int base;
        idle(3);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(int'(irq_pulse), 0, "R1 pulse");
        chk(int'(flag_word), 0, "R1 word");
        chk(int'(poll_en), 0, "R1 poll enable");
        chk(int'(poll_shift), 6, "R1 poll shift");

        // R8 strobes with nothing enabled
        base = n_irq;
        strobe(0, 0, 7, 0); strobe(0, 0, 8, 0);
        idle(1);
        chk(n_irq - base, 0, "R8 ignored strobes");

        // R2 update events
        wr_en(1, 0);
        strobe(0, 0, 0, 0);
        strobe(0, 0, 1, 0);
        strobe(0, 0, 1, 0);
        strobe(0, 0, 5, 0);

        // R3 alarm coinciding with update
        wr_alarm(1, 2, 3);
        wr_en(2, 0);
        strobe(1, 2, 3, 0);
        strobe(1, 2, 3, 0);
        strobe(1, 2, 4, 0);

        // R10 clear and set in one write; periodic with limit 1
        wr_en(4, 3);
        strobe(0, 0, 9, 0); strobe(0, 0, 9, 0);

        // R4 limit 8
        wr_rate(3);
        base = n_irq;
        for (int i = 0; i < 20; i++) strobe(0, 0, 9, 0);
        idle(1);
        chk(n_irq - base, 2, "R4 limit 8 count");

        // R5 missed credit at limit 32
        wr_rate(1);
        strobe(0, 0, 9, 10); strobe(0, 0, 9, 15); strobe(0, 0, 9, 3);
        strobe(0, 0, 9, 15); strobe(0, 0, 9, 15);

        // R9 fast rate, R6 clamps
        wr_rate(10);
        strobe(0, 0, 9, 0);
        wr_rate(0);
        idle(1);
        chk(int'(poll_shift), 6, "R6 low clamp");
        wr_rate(15);
        idle(1);
        chk(int'(poll_shift), 13, "R6 high clamp");

        // all three events on one strobe
        wr_rate(6);
        wr_en(3, 0);
        wr_alarm(4, 5, 6);
        strobe(4, 5, 6, 0);

        // R10 write in strobe cycle judged with old settings
        @(negedge clk);
        poll_strobe = 1; cur_sec = 6'd7; en_clr = 3'b111;
        @(negedge clk);
        poll_strobe = 0; en_clr = 0;
        chk(int'(irq_pulse), 1, "R10 strobe uses old enables");
        chk(int'(poll_en), 0, "R10 enables cleared");
        strobe(0, 0, 8, 0);

        // R10 set wins over clear on same bit
        wr_en(1, 1);
        chk(int'(poll_en), 1, "R10 set wins");
        idle(2);
        report();
    end

endmodule